// File: doc/BRIEF.md
# Write-Update Snooping Line Controller

This block is the coherence controller of one private cache that takes part in a write-update snooping protocol. Each cache line holds a single data word in a small direct-mapped array. A resident line is in one of four states: Exclusive (the only copy, clean), Shared-Clean, Shared-Modified (the single owner among the sharers, which supplies the line) or Modified (the only copy, dirty). No state marks a resident line invalid. A copy changes only when the cache writes the line, when a snooped update rewrites it in place, or when a new tag replaces it in the same slot.

The processor side is a held request with a one-cycle completion pulse. The cache issues transactions on the shared bus with a valid/grant pair. A transaction takes effect in the cycle where valid and grant are both high. In that same cycle the bus supplies the wired-OR shared line, and for a read it also supplies the fill word. The snoop side receives the transactions of other caches one cycle at a time. In the same cycle the block answers with its contribution to the shared line and, when it owns dirty data, a flush of the line word. The processor must hold its request fields stable until the completion pulse. The bus must never grant this cache's own request in a cycle that also carries a snoop. A snoop that arrives while the block is idle takes priority: a processor request waits until the snoop cycle has passed.

Top module: `dragon_ctrl`

## Requirements
- R1: After reset no line is resident. `cpu_done` and `bus_req_valid` are low, and a snoop of any address answers with `snp_shared` and `snp_flush` low.
- R2: A read miss issues one read transaction (`bus_req_cmd` = 1) and returns the fill word on `cpu_rdata`. The line fills to Exclusive if `bus_shared_in` is low during the grant cycle, and to Shared-Clean if it is high.
- R3: A read hit in any state completes with no bus transaction and returns the stored word.
- R4: A write hit on a Shared-Clean or Shared-Modified line issues one update transaction (`bus_req_cmd` = 2) that carries the written word on `bus_req_data`. The line ends in Shared-Modified if the shared line is high during the grant cycle, and in Modified if it is low.
- R5: A write hit on an Exclusive line goes to Modified with no bus transaction. A write hit on a Modified line stays Modified with no bus transaction.
- R6: A write miss first issues a read. If the shared line was low, it stops there and the line is Modified holding the written word. If the shared line was high, an update carrying the word follows, and the line ends in Shared-Modified.
- R7: A snooped update (`snp_cmd` = 2) to a resident line writes `snp_data` into the copy. A Shared-Modified copy drops to Shared-Clean, which leaves at most one owner among the sharers.
- R8: A snooped read (`snp_cmd` = 1) to a Modified or Shared-Modified line raises `snp_flush` and drives the line word on `snp_flush_data`, which is zero otherwise. Modified then becomes Shared-Modified and Exclusive becomes Shared-Clean.
- R9: `snp_shared` is high in the very cycle that a snooped read or update addresses a resident line. It is low in every other case.
- R10: A miss whose slot holds a Modified or Shared-Modified line first writes that line back (`bus_req_cmd` = 3, with the old address and word), then performs the fill. A victim in Exclusive or Shared-Clean is replaced silently.
- R11: A snoop whose tag differs from the resident tag neither answers nor changes the resident line.
- R12: `cpu_done` is a one-cycle pulse. A request held without grant keeps its command. A granted update always completes the processor access in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor access request, held until done |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address (low IDX_W bits index the array) |
| cpu_wdata | input | DATA_W | Word to write |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Read result, valid with cpu_done |
| bus_req_valid | output | 1 | Bus transaction request |
| bus_req_cmd | output | 2 | 1 read, 2 update, 3 writeback |
| bus_req_addr | output | ADDR_W | Transaction address |
| bus_req_data | output | DATA_W | Update or writeback word |
| bus_gnt | input | 1 | Grant; transaction occurs when valid and grant are high |
| bus_shared_in | input | 1 | Wired-OR shared line from other caches |
| bus_fill_data | input | DATA_W | Fill word during a granted read |
| snp_valid | input | 1 | Snooped transaction present |
| snp_cmd | input | 2 | Snooped command, same encoding |
| snp_addr | input | ADDR_W | Snooped address |
| snp_data | input | DATA_W | Snooped update word |
| snp_shared | output | 1 | This cache's drive onto the shared line |
| snp_flush | output | 1 | This cache supplies the line |
| snp_flush_data | output | DATA_W | Supplied word |

## Verification
The snoop answers on `snp_shared`, `snp_flush` and `snp_flush_data` are combinational. The bench drives a snoop at the falling edge and samples the answers a little later in the same cycle. The state change that the snoop causes is visible only after the next rising edge, so the bench reads it back through a later snoop or a later processor access. Bus requests appear one edge after the processor request is taken, or one edge after the previous grant. The bench grants each request at the falling edge after it appears, and records the command and the update word in that cycle. `cpu_done` and `cpu_rdata` arrive one edge after the hit or the final grant, and the bench samples them at the following falling edge before it releases the request.

// File: rtl/dragon_pkg.sv
package dragon_pkg;

   typedef enum logic [2:0] {
      LS_NONE  = 3'd0,
      LS_EXCL  = 3'd1,
      LS_SHCLN = 3'd2,
      LS_SHMOD = 3'd3,
      LS_MOD   = 3'd4
   } line_st_e;

   typedef enum logic [1:0] {
      BC_IDLE   = 2'd0,
      BC_READ   = 2'd1,
      BC_UPDATE = 2'd2,
      BC_WBACK  = 2'd3
   } bus_cmd_e;

   typedef enum logic [2:0] {
      SQ_IDLE, SQ_WBACK, SQ_FILL, SQ_UPD, SQ_DONE
   } seq_st_e;

   function automatic logic st_dirty(line_st_e s);
      return (s == LS_SHMOD) || (s == LS_MOD);
   endfunction

endpackage

// File: rtl/dragon_line_store.sv
module dragon_line_store
   import dragon_pkg::*;
#(
   parameter int IDX_W  = 2,
   parameter int TAG_W  = 6,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   // sequencer write port
   input  logic              a_wr_en,
   input  logic [IDX_W-1:0]  a_idx,
   input  logic [TAG_W-1:0]  a_tag,
   input  line_st_e          a_st,
   input  logic              a_data_en,
   input  logic [DATA_W-1:0] a_data,
   // snoop write port (wins on a collision)
   input  logic              b_wr_en,
   input  logic [IDX_W-1:0]  b_idx,
   input  line_st_e          b_st,
   input  logic              b_data_en,
   input  logic [DATA_W-1:0] b_data,
   // read ports
   input  logic [IDX_W-1:0]  ra_idx,
   output line_st_e          ra_st,
   output logic [TAG_W-1:0]  ra_tag,
   output logic [DATA_W-1:0] ra_data,
   input  logic [IDX_W-1:0]  rb_idx,
   output line_st_e          rb_st,
   output logic [TAG_W-1:0]  rb_tag,
   output logic [DATA_W-1:0] rb_data
);

   localparam int NLINES = 1 << IDX_W;

   line_st_e          st_arr  [NLINES];
   logic [TAG_W-1:0]  tag_arr [NLINES];
   logic [DATA_W-1:0] dat_arr [NLINES];

   for (genvar i = 0; i < NLINES; i++) begin : g_line
      localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(i);
      line_st_e          st_q;
      logic [TAG_W-1:0]  tag_q;
      logic [DATA_W-1:0] dat_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            st_q  <= LS_NONE;
            tag_q <= '0;
            dat_q <= '0;
         end else if (b_wr_en && (b_idx == MY_IDX)) begin
            st_q <= b_st;
            if (b_data_en) dat_q <= b_data;
         end else if (a_wr_en && (a_idx == MY_IDX)) begin
            st_q  <= a_st;
            tag_q <= a_tag;
            if (a_data_en) dat_q <= a_data;
         end
      end

      assign st_arr[i]  = st_q;
      assign tag_arr[i] = tag_q;
      assign dat_arr[i] = dat_q;
   end

   assign ra_st   = st_arr[ra_idx];
   assign ra_tag  = tag_arr[ra_idx];
   assign ra_data = dat_arr[ra_idx];
   assign rb_st   = st_arr[rb_idx];
   assign rb_tag  = tag_arr[rb_idx];
   assign rb_data = dat_arr[rb_idx];

endmodule

// File: rtl/dragon_snoop_unit.sv
module dragon_snoop_unit
   import dragon_pkg::*;
#(
   parameter int TAG_W  = 6,
   parameter int DATA_W = 16
) (
   input  logic              snp_valid,
   input  logic [1:0]        snp_cmd,
   input  logic [TAG_W-1:0]  snp_tag,
   input  logic [DATA_W-1:0] snp_data,
   input  line_st_e          cur_st,
   input  logic [TAG_W-1:0]  cur_tag,
   input  logic [DATA_W-1:0] cur_data,
   output logic              shared_o,
   output logic              flush_o,
   output logic [DATA_W-1:0] flush_data_o,
   output logic              wr_en_o,
   output line_st_e          nxt_st_o,
   output logic              data_en_o,
   output logic [DATA_W-1:0] data_o
);

   logic held, is_rd, is_up;

   always_comb begin
      held  = snp_valid && (cur_st != LS_NONE) && (cur_tag == snp_tag);
      is_rd = (snp_cmd == BC_READ);
      is_up = (snp_cmd == BC_UPDATE);

      shared_o     = held && (is_rd || is_up);
      flush_o      = held && is_rd && st_dirty(cur_st);
      flush_data_o = flush_o ? cur_data : '0;

      wr_en_o   = shared_o;
      data_en_o = held && is_up;
      data_o    = snp_data;
      nxt_st_o  = cur_st;
      if (is_rd) begin
         if (cur_st == LS_EXCL)     nxt_st_o = LS_SHCLN;
         else if (cur_st == LS_MOD) nxt_st_o = LS_SHMOD;
      end else if (is_up) begin
         if (cur_st == LS_SHMOD)    nxt_st_o = LS_SHCLN;
      end
   end

endmodule

// File: rtl/dragon_proc_seq.sv
module dragon_proc_seq
   import dragon_pkg::*;
#(
   parameter int TAG_W  = 6,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [TAG_W-1:0]  cpu_tag,
   input  logic [DATA_W-1:0] cpu_wdata,
   input  logic              snp_busy,
   input  logic              bus_gnt,
   input  logic              bus_shared,
   input  logic [DATA_W-1:0] bus_fill,
   input  line_st_e          cur_st,
   input  logic [TAG_W-1:0]  cur_tag,
   input  logic [DATA_W-1:0] cur_data,
   output logic              cpu_done,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              req_valid,
   output logic [1:0]        req_cmd,
   output logic [TAG_W-1:0]  req_tag,
   output logic [DATA_W-1:0] req_data,
   output logic              wr_en,
   output line_st_e          wr_st,
   output logic              wr_data_en,
   output logic [DATA_W-1:0] wr_data
);

   seq_st_e           st_q, st_d;
   logic              load_rd;
   logic [DATA_W-1:0] rd_val;
   logic [DATA_W-1:0] rdata_q;
   logic              hit;

   always_comb begin
      hit        = (cur_st != LS_NONE) && (cur_tag == cpu_tag);
      st_d       = st_q;
      load_rd    = 1'b0;
      rd_val     = cur_data;
      req_valid  = 1'b0;
      req_cmd    = BC_IDLE;
      req_tag    = cpu_tag;
      req_data   = '0;
      wr_en      = 1'b0;
      wr_st      = LS_NONE;
      wr_data_en = 1'b0;
      wr_data    = cpu_wdata;
      unique case (st_q)
         SQ_IDLE: if (cpu_req && !snp_busy) begin
            if (hit) begin
               if (!cpu_we) begin
                  load_rd = 1'b1;
                  st_d    = SQ_DONE;
               end else if ((cur_st == LS_EXCL) || (cur_st == LS_MOD)) begin
                  wr_en      = 1'b1;
                  wr_st      = LS_MOD;
                  wr_data_en = 1'b1;
                  st_d       = SQ_DONE;
               end else begin
                  st_d = SQ_UPD;
               end
            end else begin
               st_d = st_dirty(cur_st) ? SQ_WBACK : SQ_FILL;
            end
         end
         SQ_WBACK: begin
            req_valid = 1'b1;
            req_cmd   = BC_WBACK;
            req_tag   = cur_tag;
            req_data  = cur_data;
            if (bus_gnt) st_d = SQ_FILL;
         end
         SQ_FILL: begin
            req_valid = 1'b1;
            req_cmd   = BC_READ;
            if (bus_gnt) begin
               wr_en      = 1'b1;
               wr_data_en = 1'b1;
               if (!cpu_we) begin
                  wr_st   = bus_shared ? LS_SHCLN : LS_EXCL;
                  wr_data = bus_fill;
                  load_rd = 1'b1;
                  rd_val  = bus_fill;
                  st_d    = SQ_DONE;
               end else if (bus_shared) begin
                  wr_st   = LS_SHCLN;
                  wr_data = bus_fill;
                  st_d    = SQ_UPD;
               end else begin
                  wr_st = LS_MOD;
                  st_d  = SQ_DONE;
               end
            end
         end
         SQ_UPD: begin
            req_valid = 1'b1;
            req_cmd   = BC_UPDATE;
            req_data  = cpu_wdata;
            if (bus_gnt) begin
               wr_en      = 1'b1;
               wr_st      = bus_shared ? LS_SHMOD : LS_MOD;
               wr_data_en = 1'b1;
               st_d       = SQ_DONE;
            end
         end
         SQ_DONE: st_d = SQ_IDLE;
         default: st_d = SQ_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= SQ_IDLE;
         rdata_q <= '0;
      end else begin
         st_q <= st_d;
         if (load_rd) rdata_q <= rd_val;
      end
   end

   assign cpu_done  = (st_q == SQ_DONE);
   assign cpu_rdata = rdata_q;

endmodule

// File: rtl/dragon_ctrl.sv
module dragon_ctrl
   import dragon_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int IDX_W  = 2,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic              cpu_done,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              bus_req_valid,
   output logic [1:0]        bus_req_cmd,
   output logic [ADDR_W-1:0] bus_req_addr,
   output logic [DATA_W-1:0] bus_req_data,
   input  logic              bus_gnt,
   input  logic              bus_shared_in,
   input  logic [DATA_W-1:0] bus_fill_data,
   input  logic              snp_valid,
   input  logic [1:0]        snp_cmd,
   input  logic [ADDR_W-1:0] snp_addr,
   input  logic [DATA_W-1:0] snp_data,
   output logic              snp_shared,
   output logic              snp_flush,
   output logic [DATA_W-1:0] snp_flush_data
);

   localparam int TAG_W = ADDR_W - IDX_W;

   if (IDX_W < 1 || IDX_W > 10) begin : g_bad_idx
      $error("dragon_ctrl: IDX_W must lie in 1..10");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("dragon_ctrl: ADDR_W must exceed IDX_W");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("dragon_ctrl: DATA_W must be positive");
   end

   logic [IDX_W-1:0]  c_idx, s_idx;
   logic [TAG_W-1:0]  c_tag, s_tag;
   line_st_e          ra_st, rb_st;
   logic [TAG_W-1:0]  ra_tag, rb_tag;
   logic [DATA_W-1:0] ra_data, rb_data;

   logic              a_wr_en, a_data_en;
   line_st_e          a_st;
   logic [DATA_W-1:0] a_data;
   logic              b_wr_en, b_data_en;
   line_st_e          b_st;
   logic [DATA_W-1:0] b_data;
   logic [TAG_W-1:0]  req_tag;

   assign c_idx = cpu_addr[IDX_W-1:0];
   assign c_tag = cpu_addr[ADDR_W-1:IDX_W];
   assign s_idx = snp_addr[IDX_W-1:0];
   assign s_tag = snp_addr[ADDR_W-1:IDX_W];

   dragon_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .a_wr_en   (a_wr_en),
      .a_idx     (c_idx),
      .a_tag     (c_tag),
      .a_st      (a_st),
      .a_data_en (a_data_en),
      .a_data    (a_data),
      .b_wr_en   (b_wr_en),
      .b_idx     (s_idx),
      .b_st      (b_st),
      .b_data_en (b_data_en),
      .b_data    (b_data),
      .ra_idx    (c_idx),
      .ra_st     (ra_st),
      .ra_tag    (ra_tag),
      .ra_data   (ra_data),
      .rb_idx    (s_idx),
      .rb_st     (rb_st),
      .rb_tag    (rb_tag),
      .rb_data   (rb_data)
   );

   dragon_snoop_unit #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_snoop (
      .snp_valid    (snp_valid),
      .snp_cmd      (snp_cmd),
      .snp_tag      (s_tag),
      .snp_data     (snp_data),
      .cur_st       (rb_st),
      .cur_tag      (rb_tag),
      .cur_data     (rb_data),
      .shared_o     (snp_shared),
      .flush_o      (snp_flush),
      .flush_data_o (snp_flush_data),
      .wr_en_o      (b_wr_en),
      .nxt_st_o     (b_st),
      .data_en_o    (b_data_en),
      .data_o       (b_data)
   );

   dragon_proc_seq #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .cpu_req    (cpu_req),
      .cpu_we     (cpu_we),
      .cpu_tag    (c_tag),
      .cpu_wdata  (cpu_wdata),
      .snp_busy   (snp_valid),
      .bus_gnt    (bus_gnt),
      .bus_shared (bus_shared_in),
      .bus_fill   (bus_fill_data),
      .cur_st     (ra_st),
      .cur_tag    (ra_tag),
      .cur_data   (ra_data),
      .cpu_done   (cpu_done),
      .cpu_rdata  (cpu_rdata),
      .req_valid  (bus_req_valid),
      .req_cmd    (bus_req_cmd),
      .req_tag    (req_tag),
      .req_data   (bus_req_data),
      .wr_en      (a_wr_en),
      .wr_st      (a_st),
      .wr_data_en (a_data_en),
      .wr_data    (a_data)
   );

   assign bus_req_addr = {req_tag, c_idx};

endmodule

// File: rtl/dragon_ctrl_chk.sv
module dragon_ctrl_chk #(
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic [DATA_W-1:0] cpu_wdata,
   input logic              cpu_done,
   input logic              bus_req_valid,
   input logic [1:0]        bus_req_cmd,
   input logic [DATA_W-1:0] bus_req_data,
   input logic              bus_gnt,
   input logic              snp_valid,
   input logic [1:0]        snp_cmd,
   input logic              snp_shared,
   input logic              snp_flush
);

   p_flush_implies_shared_r8: assert property (@(posedge clk) disable iff (!rst_n)
      snp_flush |-> snp_shared);

   p_flush_on_read_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
      snp_flush |-> (snp_cmd == 2'd1));

   p_quiet_without_snoop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !snp_valid |-> !snp_shared);

   p_done_single_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_done |=> !cpu_done);

   p_req_held_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req_valid && !bus_gnt) |=> (bus_req_valid && $stable(bus_req_cmd)));

   p_upd_finishes_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req_valid && bus_gnt && bus_req_cmd == 2'd2) |=> cpu_done);

   p_upd_carries_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req_valid && bus_req_cmd == 2'd2) |-> (bus_req_data == cpu_wdata));

   p_fill_after_wb_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req_valid && bus_gnt && bus_req_cmd == 2'd3) |=>
         (bus_req_valid && bus_req_cmd == 2'd1));

   p_no_done_while_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req_valid |-> !cpu_done);

endmodule

bind dragon_ctrl dragon_ctrl_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_dragon_ctrl.sv
module tb_dragon_ctrl;

   localparam int AW = 8;
   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cpu_req = 1'b0, cpu_we = 1'b0;
   logic [AW-1:0] cpu_addr = '0;
   logic [DW-1:0] cpu_wdata = '0;
   logic          cpu_done;
   logic [DW-1:0] cpu_rdata;
   logic          bus_req_valid;
   logic [1:0]    bus_req_cmd;
   logic [AW-1:0] bus_req_addr;
   logic [DW-1:0] bus_req_data;
   logic          bus_gnt = 1'b0, bus_shared_in = 1'b0;
   logic [DW-1:0] bus_fill_data = '0;
   logic          snp_valid = 1'b0;
   logic [1:0]    snp_cmd = '0;
   logic [AW-1:0] snp_addr = '0;
   logic [DW-1:0] snp_data = '0;
   logic          snp_shared, snp_flush;
   logic [DW-1:0] snp_flush_data;

   int checks = 0;
   int errors = 0;
   logic [AW-1:0] wb_addr = '0;
   logic [DW-1:0] wb_data = '0;

   always #10 clk = ~clk;

   dragon_ctrl #(.ADDR_W(AW), .IDX_W(2), .DATA_W(DW)) dut (.*);

   // vector: kind, addr, data, shared, expected command log, expected word, expected {shared,flush}
   localparam logic [1:0] K_RD = 2'd0, K_WR = 2'd1, K_SRD = 2'd2, K_SUP = 2'd3;
   localparam int VW = 51;
   localparam int NV = 30;
   localparam logic [VW-1:0] VEC [NV] = '{
      {K_RD,  8'h05, 16'h0000, 1'b0, 6'h01, 16'hF005, 2'b00}, // R2 miss, Exclusive
      {K_RD,  8'h05, 16'h0000, 1'b0, 6'h00, 16'hF005, 2'b00}, // R3 hit
      {K_SRD, 8'h05, 16'h0000, 1'b0, 6'h00, 16'h0000, 2'b10}, // R8 R9 E to Sc
      {K_WR,  8'h05, 16'h1111, 1'b1, 6'h02, 16'h0000, 2'b00}, // R4 Sc to Sm
      {K_SRD, 8'h05, 16'h0000, 1'b0, 6'h00, 16'h1111, 2'b11}, // R8 Sm flush
      {K_SUP, 8'h05, 16'h2222, 1'b0, 6'h00, 16'h0000, 2'b10}, // R7 Sm to Sc
      {K_RD,  8'h05, 16'h0000, 1'b0, 6'h00, 16'h2222, 2'b00}, // R7 word applied
      {K_SRD, 8'h05, 16'h0000, 1'b0, 6'h00, 16'h0000, 2'b10}, // R7 no longer owner
      {K_WR,  8'h05, 16'h3333, 1'b0, 6'h02, 16'h0000, 2'b00}, // R4 Sc to M
      {K_WR,  8'h05, 16'h4444, 1'b0, 6'h00, 16'h0000, 2'b00}, // R5 M stays M
      {K_SRD, 8'h05, 16'h0000, 1'b0, 6'h00, 16'h4444, 2'b11}, // R8 M flush to Sm
      {K_WR,  8'h05, 16'h5555, 1'b0, 6'h02, 16'h0000, 2'b00}, // R4 Sm to M
      {K_RD,  8'h06, 16'h0000, 1'b1, 6'h01, 16'hF006, 2'b00}, // R2 miss shared, Sc
      {K_SRD, 8'h06, 16'h0000, 1'b0, 6'h00, 16'h0000, 2'b10}, // R9 Sc answers
      {K_WR,  8'h07, 16'h7777, 1'b0, 6'h01, 16'h0000, 2'b00}, // R6 miss unshared
      {K_SRD, 8'h07, 16'h0000, 1'b0, 6'h00, 16'h7777, 2'b11}, // R6 M holds word
      {K_WR,  8'h04, 16'h8888, 1'b1, 6'h09, 16'h0000, 2'b00}, // R6 miss shared
      {K_SRD, 8'h04, 16'h0000, 1'b0, 6'h00, 16'h8888, 2'b11}, // R6 ends Sm
      {K_RD,  8'h08, 16'h0000, 1'b0, 6'h07, 16'hF008, 2'b00}, // R10 dirty victim
      {K_SRD, 8'h04, 16'h0000, 1'b0, 6'h00, 16'h0000, 2'b00}, // R11 evicted tag
      {K_WR,  8'h08, 16'h9999, 1'b0, 6'h00, 16'h0000, 2'b00}, // R5 E to M silent
      {K_SUP, 8'h0C, 16'hDEAD, 1'b0, 6'h00, 16'h0000, 2'b00}, // R11 other tag
      {K_SRD, 8'h08, 16'h0000, 1'b0, 6'h00, 16'h9999, 2'b11}, // R11 R5 untouched
      {K_RD,  8'h0D, 16'h0000, 1'b0, 6'h07, 16'hF00D, 2'b00}, // R10 M victim
      {K_RD,  8'h06, 16'h0000, 1'b0, 6'h00, 16'hF006, 2'b00}, // R3 Sc hit
      {K_WR,  8'h06, 16'hAAAA, 1'b1, 6'h02, 16'h0000, 2'b00}, // R4 Sc to Sm
      {K_RD,  8'h0A, 16'h0000, 1'b1, 6'h07, 16'hF00A, 2'b00}, // R10 Sm victim
      {K_WR,  8'h0A, 16'hBBBB, 1'b0, 6'h02, 16'h0000, 2'b00}, // R4 Sc to M
      {K_WR,  8'h0B, 16'hCCCC, 1'b1, 6'h27, 16'h0000, 2'b00}, // R10 R6 wb, rd, upd
      {K_SRD, 8'h0B, 16'h0000, 1'b0, 6'h00, 16'hCCCC, 2'b11}  // R6 ends Sm
   };

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic do_cpu(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input logic shr, output logic [5:0] log, output logic [DW-1:0] rd,
                         output logic ok);
      int n = 0;
      log = '0; rd = '0; ok = 1'b0;
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
      for (int it = 0; it < 20; it++) begin
         @(negedge clk);
         bus_gnt = 1'b0; bus_shared_in = 1'b0; bus_fill_data = '0;
         if (cpu_done) begin
            rd = cpu_rdata; ok = 1'b1; cpu_req = 1'b0;
            break;
         end
         if (bus_req_valid) begin
            log = log | (6'(bus_req_cmd) << (2 * n));
            n++;
            if (bus_req_cmd == 2'd2) check("R4", "update word", 32'(bus_req_data), 32'(d));
            if (bus_req_cmd == 2'd3) begin wb_addr = bus_req_addr; wb_data = bus_req_data; end
            bus_gnt = 1'b1; bus_shared_in = shr;
            bus_fill_data = 16'hF000 | 16'(bus_req_addr);
         end
      end
      cpu_req = 1'b0;
   endtask

   task automatic do_snoop(input logic [1:0] cmd, input logic [AW-1:0] a, input logic [DW-1:0] d,
                           output logic [1:0] flags, output logic [DW-1:0] fd);
      @(negedge clk);
      snp_valid = 1'b1; snp_cmd = cmd; snp_addr = a; snp_data = d;
      #1;
      flags = {snp_shared, snp_flush};
      fd = snp_flush_data;
      @(negedge clk);
      snp_valid = 1'b0; snp_cmd = '0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [5:0]    lg;
      logic [DW-1:0] rd, fd;
      logic [1:0]    fl;
      logic          ok;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1", "cpu_done", 32'(cpu_done), 32'd0);
      check("R1", "bus_req_valid", 32'(bus_req_valid), 32'd0);
      do_snoop(2'd1, 8'h05, '0, fl, fd);
      check("R1", "snoop flags", 32'(fl), 32'd0);

      for (int i = 0; i < NV; i++) begin
         logic [1:0]    k;
         logic [AW-1:0] a;
         logic [DW-1:0] d, ew;
         logic          s;
         logic [5:0]    el;
         logic [1:0]    ef;
         {k, a, d, s, el, ew, ef} = VEC[i];
         if (k == K_RD || k == K_WR) begin
            do_cpu(k == K_WR, a, d, s, lg, rd, ok);
            check("R12", $sformatf("vec %0d completion", i), 32'(ok), 32'd1);
            check("R2/R5/R6/R10", $sformatf("vec %0d bus log", i), 32'(lg), 32'(el));
            if (k == K_RD) check("R2/R3", $sformatf("vec %0d read word", i), 32'(rd), 32'(ew));
         end else begin
            do_snoop(k == K_SRD ? 2'd1 : 2'd2, a, d, fl, fd);
            check("R7/R8/R9/R11", $sformatf("vec %0d snoop flags", i), 32'(fl), 32'(ef));
            check("R8", $sformatf("vec %0d flush word", i), 32'(fd), 32'(ew));
         end
      end

      // R10 last writeback carried the old address and word
      check("R10", "writeback addr", 32'(wb_addr), 32'h07);
      check("R10", "writeback word", 32'(wb_data), 32'h7777);

      // R12 pulse lasts one cycle
      check("R12", "done after release", 32'(cpu_done), 32'd0);

      // R1 reset mid-run clears residency
      @(negedge clk); rst_n = 1'b0;
      repeat (2) @(negedge clk); rst_n = 1'b1;
      do_snoop(2'd1, 8'h0B, '0, fl, fd);
      check("R1", "flags after reset", 32'(fl), 32'd0);
      do_cpu(1'b0, 8'h0B, '0, 1'b0, lg, rd, ok);
      check("R1", "miss after reset", 32'(lg), 32'h01);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule